// File: doc/BRIEF.md
# Servo Pulse Angle Decoder

This block watches a single pulse-width-modulated control line, as used to command a hobby servo, and turns each observed frame into a coarse angle. It runs in one clock domain. The input is synchronised, its edges are found, and two counters measure the interval between consecutive rising edges (the frame period) and the high time that follows each rising edge (the pulse width). All time limits are turned into cycle counts at elaboration from the `CLK_HZ` parameter.

A frame counts only when its period lies inside the servo frame window of 15 ms to 25 ms. The pulse width of such a frame is mapped to one of six angles spaced 30 degrees apart. A result is reported only when the period or the width differs from the previous measurement, so a steady command produces one strobe and then nothing. If the line stays quiet long enough, the measurement in progress is thrown away.

Top module: `servo_angle_decoder`

## Requirements
- R1: A measurement is eligible for output only if its period, counted in clock cycles from one rising edge to the next, lies within the inclusive range of 15 ms to 25 ms in cycles (1500 to 2500 cycles at 100 kHz). Periods outside this range never raise `angle_vld`.
- R2: A pulse width below 0.9 ms gives angle 0. From 0.9 ms up to but not including 1.2 ms it gives 30. From 1.2 ms up to but not including 1.5 ms it gives 60. From 1.5 ms up to but not including 1.8 ms it gives 90.
- R3: A width from 1.8 ms up to but not including 2.1 ms gives 120, and a width of 2.1 ms or more gives 150.
- R4: An angle is emitted only when the measured period or the measured width differs from the previously recorded pair. A frame identical to the last recorded one produces no strobe.
- R5: The recorded period and width are replaced after every completed measurement, including measurements rejected by the window of R1.
- R6: The period is the number of cycles between two synchronised rising edges, and the width is the number of cycles the synchronised input stays high after the first of them. The first rising edge after reset or after a timeout only starts a measurement and produces nothing.
- R7: If no rising edge follows within 30 ms of cycles (25 ms plus a 5 ms margin), the period counter saturates at that limit without wrapping. The measurement is discarded and leaves the recorded pair unchanged.
- R8: `angle_vld` is high for exactly one cycle per emitted angle. `angle` is an unsigned 8-bit value that changes only together with `angle_vld`. After reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_in | input | 1 | Servo control line, asynchronous to `clk` |
| angle | output | 8 | Last emitted angle in degrees (0, 30, 60, 90, 120 or 150) |
| angle_vld | output | 1 | One-cycle strobe marking a new `angle` |

## Verification
On every cycle the assertions check the following: the strobe never lasts two cycles, the angle holds still between strobes and is always one of the six legal codes, a measurement whose period falls outside the window or whose pair matches the recorded one is never followed by a strobe, the measured width never exceeds the measured period, and the period counter never passes its timeout limit. The bench scenarios cover what the assertions cannot show. These are the exact angle chosen on either side of each width threshold, acceptance at both window edges and rejection just outside them, the fact that a rejected frame still replaces the recorded pair, and the discarding of a frame stretched by a long idle gap.

// File: rtl/servo_dec_pkg.sv
package servo_dec_pkg;

  // timing constants in microseconds
  localparam longint unsigned WIN_MIN_US   = 15000;
  localparam longint unsigned WIN_MAX_US   = 25000;
  localparam longint unsigned TIMEOUT_US   = 30000;
  localparam longint unsigned BIN_FIRST_US = 900;
  localparam longint unsigned BIN_STEP_US  = 300;

  // angle coding
  localparam int NUM_BINS   = 6;
  localparam int ANGLE_STEP = 30;
  localparam int ANGLE_W    = 8;

  function automatic int unsigned us_to_cyc(input longint unsigned clk_hz,
                                            input longint unsigned usec);
    return 32'((clk_hz * usec) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/servo_edge_sync.sv
module servo_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its delayed copy
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/servo_pulse_meter.sv
module servo_pulse_meter #(
  parameter int          CNT_W   = 16,
  parameter int unsigned TMO_CYC = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  output logic             meas_stb,
  output logic [CNT_W-1:0] meas_per,
  output logic [CNT_W-1:0] meas_wid,
  output logic [CNT_W-1:0] per_cnt
);

  localparam logic [CNT_W-1:0] TMO_V = CNT_W'(TMO_CYC);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] per_q, per_nxt;
  logic [CNT_W-1:0] hi_q, hi_nxt;
  logic             run_q, run_nxt;
  logic             armed_q, armed_nxt;
  logic             stb_q, stb_nxt;
  logic [CNT_W-1:0] mper_q, mwid_q;
  logic             cap_en;

  always_comb begin
    // period counter: restarts on a rising edge, saturates at the timeout
    if (rise)               per_nxt = ONE;
    else if (per_q == TMO_V) per_nxt = per_q;
    else                    per_nxt = per_q + ONE;

    // high-time counter: runs from a rising edge until the falling edge
    if (rise)                                   hi_nxt = ONE;
    else if (run_q && !fall && hi_q != TMO_V)   hi_nxt = hi_q + ONE;
    else                                        hi_nxt = hi_q;

    if (rise)      run_nxt = 1'b1;
    else if (fall) run_nxt = 1'b0;
    else           run_nxt = run_q;

    armed_nxt = armed_q | rise;

    // a closing edge completes a measurement unless the frame timed out
    cap_en  = rise & armed_q & (per_q < TMO_V);
    stb_nxt = cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '0;
      hi_q    <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      per_q   <= per_nxt;
      hi_q    <= hi_nxt;
      run_q   <= run_nxt;
      armed_q <= armed_nxt;
      stb_q   <= stb_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mper_q <= '0;
      mwid_q <= '0;
    end else if (cap_en) begin
      mper_q <= per_q;
      mwid_q <= hi_q;
    end
  end

  assign meas_stb = stb_q;
  assign meas_per = mper_q;
  assign meas_wid = mwid_q;
  assign per_cnt  = per_q;

endmodule

// File: rtl/servo_angle_quant.sv
module servo_angle_quant
  import servo_dec_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int              CNT_W  = 16
) (
  input  logic [CNT_W-1:0]   wid,
  output logic [ANGLE_W-1:0] angle
);

  localparam int NUM_THR = NUM_BINS - 1;

  logic [NUM_THR-1:0] over;

  // one comparator per bin boundary, boundaries evenly spaced
  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    localparam int unsigned THR_CYC =
      us_to_cyc(CLK_HZ, BIN_FIRST_US + BIN_STEP_US * longint'(k));
    assign over[k] = (wid >= CNT_W'(THR_CYC));
  end

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < NUM_THR; i++) begin
      n = n + int'(over[i]);
    end
    angle = ANGLE_W'(n * ANGLE_STEP);
  end

endmodule

// File: rtl/servo_angle_decoder.sv
module servo_angle_decoder
  import servo_dec_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 50_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  output logic [7:0] angle,
  output logic       angle_vld
);

  localparam int unsigned WIN_LO  = us_to_cyc(CLK_HZ, WIN_MIN_US);
  localparam int unsigned WIN_HI  = us_to_cyc(CLK_HZ, WIN_MAX_US);
  localparam int unsigned TMO_CYC = us_to_cyc(CLK_HZ, TIMEOUT_US);
  localparam int          CNT_W   = $clog2(TMO_CYC + 1);

  logic             lvl, rise, fall;
  logic             meas_stb;
  logic [CNT_W-1:0] meas_per, meas_wid, per_cnt;
  logic [7:0]       q_angle;

  logic [CNT_W-1:0] last_per_q, last_wid_q;
  logic [7:0]       angle_q, angle_nxt;
  logic             vld_q, vld_nxt;
  logic             changed, in_win, emit;

  servo_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pwm_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  servo_pulse_meter #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .meas_stb(meas_stb), .meas_per(meas_per), .meas_wid(meas_wid),
    .per_cnt(per_cnt)
  );

  servo_angle_quant #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_quant (
    .wid(meas_wid), .angle(q_angle)
  );

  always_comb begin
    changed   = (meas_per != last_per_q) || (meas_wid != last_wid_q);
    in_win    = (meas_per >= CNT_W'(WIN_LO)) && (meas_per <= CNT_W'(WIN_HI));
    emit      = meas_stb & changed & in_win;
    vld_nxt   = emit;
    angle_nxt = emit ? q_angle : angle_q;
  end

  // the recorded pair follows every completed measurement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_per_q <= '0;
      last_wid_q <= '0;
    end else if (meas_stb) begin
      last_per_q <= meas_per;
      last_wid_q <= meas_wid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      angle_q <= angle_nxt;
      vld_q   <= vld_nxt;
    end
  end

  assign angle     = angle_q;
  assign angle_vld = vld_q;

  logic unused_lvl;
  assign unused_lvl = lvl;

endmodule

// File: rtl/servo_angle_decoder_chk.sv
module servo_angle_decoder_chk
  import servo_dec_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int              CNT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       angle,
  input logic             angle_vld,
  input logic             meas_stb,
  input logic [CNT_W-1:0] meas_per,
  input logic [CNT_W-1:0] meas_wid,
  input logic [CNT_W-1:0] last_per_q,
  input logic [CNT_W-1:0] last_wid_q,
  input logic [CNT_W-1:0] per_cnt
);

  localparam int unsigned LO  = us_to_cyc(CLK_HZ, WIN_MIN_US);
  localparam int unsigned HI  = us_to_cyc(CLK_HZ, WIN_MAX_US);
  localparam int unsigned TMO = us_to_cyc(CLK_HZ, TIMEOUT_US);

  assert_strobe_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    angle_vld |=> !angle_vld);

  assert_angle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !angle_vld |-> $stable(angle));

  assert_angle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    angle_vld |-> (angle == 8'd0 || angle == 8'd30 || angle == 8'd60 ||
                   angle == 8'd90 || angle == 8'd120 || angle == 8'd150));

  assert_window_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && (meas_per < CNT_W'(LO) || meas_per > CNT_W'(HI))) |=> !angle_vld);

  assert_repeat_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && meas_per == last_per_q && meas_wid == last_wid_q) |=> !angle_vld);

  assert_width_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb |-> (meas_wid <= meas_per));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per_cnt <= CNT_W'(TMO));

endmodule

bind servo_angle_decoder servo_angle_decoder_chk #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .angle(angle), .angle_vld(angle_vld),
  .meas_stb(meas_stb), .meas_per(meas_per), .meas_wid(meas_wid),
  .last_per_q(last_per_q), .last_wid_q(last_wid_q), .per_cnt(per_cnt)
);

// File: tb/sim_servo_angle_decoder.sv
`timescale 1ns/1ps
module sim_servo_angle_decoder;

  // 100 kHz design clock rate: one cycle stands for 10 us
  localparam int WLO = 1500;
  localparam int WHI = 2500;
  localparam int TMO = 3000;

  logic       clk;
  logic       rst_n;
  logic       pwm_in;
  logic [7:0] angle;
  logic       angle_vld;

  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;

  int    exp_q[$];
  string tag_q[$];

  // reference model state
  bit    have_prev = 0;
  int    prev_h = 0, prev_p = 0;
  string prev_tag = "";
  int    last_p = 0, last_h = 0;
  bit    prev_vld = 0;

  servo_angle_decoder #(.CLK_HZ(100_000)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .angle(angle), .angle_vld(angle_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_angle(input int w);
    if (w < 90)  return 0;
    if (w < 120) return 30;
    if (w < 150) return 60;
    if (w < 180) return 90;
    if (w < 210) return 120;
    return 150;
  endfunction

  // driver: closes the previous frame in the model, then drives a new one
  task automatic frame(input int h, input int p, input string tag);
    if (have_prev && prev_p < TMO) begin
      if (((prev_p != last_p) || (prev_h != last_h)) && prev_p >= WLO && prev_p <= WHI) begin
        exp_q.push_back(exp_angle(prev_h));
        tag_q.push_back(prev_tag);
      end
      last_p = prev_p;
      last_h = prev_h;
    end
    have_prev = 1;
    prev_h = h;
    prev_p = p;
    prev_tag = tag;
    pwm_in = 1'b1;
    repeat (h) @(negedge clk);
    pwm_in = 1'b0;
    repeat (p - h) @(negedge clk);
  endtask

  task automatic idle(input int n);
    pwm_in = 1'b0;
    repeat (n) @(negedge clk);
    prev_p = prev_p + n;
  endtask

  // monitor: pops and compares each emitted angle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (angle_vld) begin
        checks++;
        if (prev_vld) begin
          errors++;
          $display("FAIL R8: strobe high two cycles, actual=1 expected=0");
        end
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4: unexpected angle, actual=%0d expected=none", angle);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (int'(angle) != e) begin
            errors++;
            $display("FAIL %s: angle actual=%0d expected=%0d", t, angle, e);
          end
        end
      end
      prev_vld = angle_vld;
    end
  end

  initial begin
    pwm_in = 1'b0;
    rst_n  = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (angle_vld !== 1'b0 || angle !== 8'd0) begin
      errors++;
      $display("FAIL R8: reset outputs actual=%0d/%0d expected=0/0", angle_vld, angle);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6: first frame only arms the measurement
    frame(60,  2000, "R2");
    frame(90,  2000, "R2");
    frame(119, 2000, "R2");
    frame(120, 2000, "R2");
    frame(149, 2000, "R2");
    frame(150, 2000, "R2");
    frame(179, 2000, "R2");
    frame(180, 2000, "R3");
    frame(209, 2000, "R3");
    frame(210, 2000, "R3");
    frame(240, 2000, "R3");
    frame(240, 2000, "R4");   // identical pair: silent
    frame(240, 2010, "R4");   // period changed: emits
    frame(100, 1499, "R1");   // below window
    frame(100, 1500, "R1");   // lower edge
    frame(100, 2500, "R1");   // upper edge
    frame(100, 2501, "R1");   // above window
    frame(100, 2000, "R5");
    frame(100, 2600, "R5");   // rejected, still recorded
    frame(100, 2000, "R5");   // differs from the rejected pair: emits
    frame(130, 2000, "R7");
    idle(1500);               // stretches period past timeout: discarded
    frame(130, 2000, "R7");
    frame(130, 2000, "R4");
    frame(50,  2000, "R6");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4: missing emissions actual=%0d expected=0 pending", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R6: watchdog expired, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule